// File: doc/BRIEF.md
# Serial DAC channel write sequencer

This block writes one 8-bit code into one channel of an eight-channel serial DAC. A start request captures a 3-bit channel number and an 8-bit code, and the block sends a 16-bit frame over a serial clock and data pair. The first byte carries the channel number moved up by one bit position. The second byte carries the code. When the last bit has been clocked, the block drives the active-low load strobe low for a fixed number of cycles. It then raises a one-cycle done flag.

The DAC moves its loaded codes to its analog outputs on a second active-low line. A separate update request drives that line, so several channels can be loaded first and then changed together. A controller that drives a stepper coil pair writes two adjacent channels, based at 0, 2, 4 or 6, and then issues one update.

The serial clock half-period is a parameter. At the system clock in use it must keep the serial clock at or below 1 MHz, and it must keep every pulse at least 250 ns wide.

Top module: `dac_write_seq`

## Requirements
- R1: While reset is asserted and right after it, `sck` is 0, `load_n` is 1, `upd_n` is 1, `busy` is 0 and `done` is 0.
- R2: A frame is 16 bits sent MSB first. Bits 15..12 are 0, bits 11..9 are the channel, bit 8 is 0 and bits 7..0 are the value, so the first byte is the channel shifted left by one.
- R3: `sck` is low whenever the block is idle. In a frame it makes exactly 16 periods, each high for SCK_HALF cycles and then low for SCK_HALF cycles, and the first period starts with a high phase.
- R4: `sdo` changes only on a clock edge where `sck` rises. It is stable while `sck` is high and when `sck` falls, which is when the DAC samples it.
- R5: `load_n` goes low 32*SCK_HALF cycles after the accepting edge, stays low for LOAD_W cycles, and is never low while `sck` is high or while the block is idle.
- R6: `done` is high for exactly one cycle, in the cycle in which `load_n` returns high.
- R7: A start request that arrives while `busy` is high is ignored. The frame in progress keeps its data and its timing, and no further frame or load pulse follows.
- R8: A one-cycle `upd_req` drives `upd_n` low from the next edge for UPD_W cycles. A request made while `upd_n` is already low does not extend or restart the pulse.
- R9: `busy` rises on the edge that accepts a start, stays high through the load pulse and the done cycle, and falls one cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to write one channel |
| chan | input | CH_W (3) | Channel to write |
| value | input | D_W (8) | Code to write |
| upd_req | input | 1 | Request for an output update pulse |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, MSB first |
| load_n | output | 1 | Active-low load strobe |
| upd_n | output | 1 | Active-low output update strobe |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Counting from the clock edge that accepts a start, the bench expects `busy` and the first rising `sck` on that same edge. It expects `load_n` low at edge 32*SCK_HALF, `load_n` high again together with `done` at edge 32*SCK_HALF+LOAD_W, and `busy` low one edge after that. The update strobe is due on the edge after its request and lasts UPD_W edges.

Inputs are driven on falling clock edges, and the outputs are sampled on every falling edge with a cycle index. Each event is recorded at the index where it was first seen, and that index is compared with the formula above. Serial bits are taken at each falling `sck`, from the value held during the high phase.

// File: rtl/dws_pkg.sv
`timescale 1ns/1ps
package dws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic        active;
        logic [15:0] cnt;
    } strobe_t;

endpackage

// File: rtl/dws_half_timer.sv
`timescale 1ns/1ps
module dws_half_timer #(
    parameter int HALF = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign tick = run && (t_q.cnt == TW'(HALF - 1));

    always_comb begin
        t_d = t_q;
        if (clear || !run || tick) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/dws_frame_shift.sv
`timescale 1ns/1ps
module dws_frame_shift #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [FW-1:0] din,
    output logic          msb
);
    typedef struct packed {
        logic [FW-1:0] sr;
    } sh_t;

    sh_t s_d, s_q;

    assign msb = s_q.sr[FW-1];

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sr = din;
        end else if (shift) begin
            s_d.sr = {s_q.sr[FW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/dws_strobe.sv
`timescale 1ns/1ps
module dws_strobe
    import dws_pkg::*;
#(
    parameter int WIDTH = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic pulse_n
);
    strobe_t p_d, p_q;

    assign pulse_n = !p_q.active;

    always_comb begin
        p_d = p_q;
        if (!p_q.active) begin
            if (req) begin
                p_d.active = 1'b1;
                p_d.cnt    = '0;
            end
        end else if (p_q.cnt == 16'(WIDTH - 1)) begin
            p_d.active = 1'b0;
            p_d.cnt    = '0;
        end else begin
            p_d.cnt = p_q.cnt + 16'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end
endmodule

// File: rtl/dac_write_seq.sv
`timescale 1ns/1ps
module dac_write_seq
    import dws_pkg::*;
#(
    parameter int CH_W     = 3,
    parameter int D_W      = 8,
    parameter int SCK_HALF = 100,
    parameter int LOAD_W   = 50,
    parameter int UPD_W    = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CH_W-1:0] chan,
    input  logic [D_W-1:0]  value,
    input  logic            upd_req,
    output logic            sck,
    output logic            sdo,
    output logic            load_n,
    output logic            upd_n,
    output logic            busy,
    output logic            done
);
    localparam int FW  = 2 * D_W;
    localparam int BW  = $clog2(FW);
    localparam int PAD = D_W - CH_W - 1;
    localparam int LCW = (LOAD_W > 1) ? $clog2(LOAD_W) : 1;

    typedef struct packed {
        seq_state_e     state;
        logic [BW-1:0]  bitn;
        logic           sck;
        logic           load_n;
        logic           done;
        logic [LCW-1:0] lcnt;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          accept;
    logic          tick;
    logic          shift_en;
    logic [FW-1:0] frame;

    assign accept = start && (c_q.state == ST_IDLE);
    assign frame  = {{PAD{1'b0}}, chan, 1'b0, value};

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        shift_en = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (accept) begin
                    c_d.state = ST_SHIFT;
                    c_d.bitn  = '0;
                    c_d.sck   = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (c_q.sck) begin
                        c_d.sck = 1'b0;
                    end else if (c_q.bitn == BW'(FW - 1)) begin
                        c_d.state  = ST_LOAD;
                        c_d.load_n = 1'b0;
                        c_d.lcnt   = '0;
                    end else begin
                        c_d.bitn = c_q.bitn + 1'b1;
                        c_d.sck  = 1'b1;
                        shift_en = 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                if (c_q.lcnt == LCW'(LOAD_W - 1)) begin
                    c_d.load_n = 1'b1;
                    c_d.done   = 1'b1;
                    c_d.state  = ST_DONE;
                end else begin
                    c_d.lcnt = c_q.lcnt + 1'b1;
                end
            end
            ST_DONE: begin
                c_d.state = ST_IDLE;
            end
            default: begin
                c_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, bitn: '0, sck: 1'b0, load_n: 1'b1,
                     done: 1'b0, lcnt: '0};
        end else begin
            c_q <= c_d;
        end
    end

    dws_half_timer #(.HALF(SCK_HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (c_q.state == ST_SHIFT),
        .tick  (tick)
    );

    dws_frame_shift #(.FW(FW)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift (shift_en),
        .din   (frame),
        .msb   (sdo)
    );

    dws_strobe #(.WIDTH(UPD_W)) u_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (upd_req),
        .pulse_n (upd_n)
    );

    assign sck    = c_q.sck;
    assign load_n = c_q.load_n;
    assign done   = c_q.done;
    assign busy   = (c_q.state != ST_IDLE);
endmodule

// File: rtl/dws_checker.sv
`timescale 1ns/1ps
module dws_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic upd_req,
    input logic sck,
    input logic sdo,
    input logic load_n,
    input logic upd_n,
    input logic busy,
    input logic done
);
    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    assert_sdo_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $rose(sck));

    assert_load_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> (busy && !sck));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_load_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(load_n));

    assert_upd_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_n) |-> $past(upd_req));

    assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind dac_write_seq dws_checker u_dws_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .upd_req (upd_req),
    .sck     (sck),
    .sdo     (sdo),
    .load_n  (load_n),
    .upd_n   (upd_n),
    .busy    (busy),
    .done    (done)
);

// File: tb/tb_dac_write_seq.sv
`timescale 1ns/1ps
module tb_dac_write_seq;
    localparam int H   = 4;
    localparam int LW  = 3;
    localparam int UW  = 5;
    localparam int TOT = 32 * H + LW;
    localparam int NV  = 6;
    // entry: {inject_second_start, chan[2:0], value[7:0]}
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h00},
        {1'b0, 3'd7, 8'hFF},
        {1'b1, 3'd2, 8'hA5},
        {1'b0, 3'd4, 8'h5A},
        {1'b1, 3'd6, 8'h80},
        {1'b0, 3'd1, 8'h01}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] chan = '0;
    logic [7:0] value = '0;
    logic       upd_req = 1'b0;
    logic       sck, sdo, load_n, upd_n, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dac_write_seq #(.SCK_HALF(H), .LOAD_W(LW), .UPD_W(UW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .value(value),
        .upd_req(upd_req), .sck(sck), .sdo(sdo), .load_n(load_n),
        .upd_n(upd_n), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_check(input string tag);
        check(sck == 1'b0, {tag, " sck"}, int'(sck), 0);
        check(load_n == 1'b1, {tag, " load_n"}, int'(load_n), 1);
        check(upd_n == 1'b1, {tag, " upd_n"}, int'(upd_n), 1);
        check(busy == 1'b0, {tag, " busy"}, int'(busy), 0);
        check(done == 1'b0, {tag, " done"}, int'(done), 0);
    endtask

    task automatic run_frame(input logic [2:0] ch, input logic [7:0] val, input bit inject);
        logic [15:0] bits = '0;
        logic [15:0] exp_frame;
        bit prev_sck = 1'b0, prev_sdo = 1'b0, hi_bad = 1'b0, busy0;
        int rises = 0, hi_run = 0, lfall = -1, lrise = -1, dn = -1, dcnt = 0, bdrop = -1;
        exp_frame = {4'b0, ch, 1'b0, val};
        @(negedge clk);
        start = 1'b1; chan = ch; value = val;
        @(negedge clk);
        start = 1'b0;
        busy0 = busy;
        for (int n = 0; n <= TOT + 2; n++) begin
            if (n > 0) @(negedge clk);
            if (inject && n == 5) begin
                start = 1'b1; chan = ~ch; value = ~val;
            end
            if (inject && n == 6) start = 1'b0;
            if (sck && !prev_sck) rises++;
            if (sck) hi_run++;
            if (!sck && prev_sck) begin
                bits = {bits[14:0], prev_sdo};
                if (hi_run != H) hi_bad = 1'b1;
                hi_run = 0;
            end
            if (!load_n && lfall < 0) lfall = n;
            if (load_n && lfall >= 0 && lrise < 0) lrise = n;
            if (done) begin dcnt++; dn = n; end
            if (!busy && bdrop < 0) bdrop = n;
            prev_sck = sck;
            prev_sdo = sdo;
        end
        check(busy0 == 1'b1, "R9 busy on accept", int'(busy0), 1);
        check(bits == exp_frame, "R2 frame bits", int'(bits), int'(exp_frame));
        check(rises == 16, "R3 sck periods", rises, 16);
        check(!hi_bad, "R3 high phase width", int'(hi_bad), 0);
        check(lfall == 32 * H, "R5 load fall cycle", lfall, 32 * H);
        check(lrise == TOT, "R5 load width", lrise, TOT);
        check(dcnt == 1 && dn == TOT, "R6 done pulse", dn, TOT);
        check(bdrop == TOT + 1, "R9 busy drop", bdrop, TOT + 1);
        if (inject) begin
            bit extra = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (busy || !load_n || sck) extra = 1'b1;
            end
            check(!extra, "R7 start while busy ignored", int'(extra), 0);
        end
    endtask

    task automatic run_update(input bit retrigger);
        int lows = 0, first = -1, back = -1;
        @(negedge clk);
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        for (int n = 0; n <= UW + 4; n++) begin
            if (n > 0) @(negedge clk);
            if (retrigger && n == 2) upd_req = 1'b1;
            if (retrigger && n == 3) upd_req = 1'b0;
            if (!upd_n) begin
                lows++;
                if (first < 0) first = n;
            end
            if (upd_n && first >= 0 && back < 0) back = n;
        end
        check(first == 0, "R8 update start", first, 0);
        check(lows == UW, "R8 update width", lows, UW);
        check(back == UW, "R8 update end", back, UW);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 after reset");
        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i][10:8], VEC[i][7:0], VEC[i][11]);
        end
        run_update(1'b0);
        run_update(1'b1);
        @(negedge clk);
        start = 1'b1; chan = 3'd3; value = 8'h3C;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        #1;
        idle_check("R1 reset mid-frame");
        @(negedge clk);
        rst_n = 1'b1;
        run_frame(3'd5, 8'hC3, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule